// File: doc/BRIEF.md
# Serial Check-Pattern Generator and Single-Error Locator

The block streams a stored 15-bit codeword through a 4-stage linear feedback shift register, one bit per clock. The codeword has eleven data bits, read in order from an external bit store through a read port, followed by four check bits taken from a switch input. Two modes share the same controller, counter and register. In generate mode (`mode` = 1) the whole codeword is shifted. Zero check bits leave the identity check pattern in the register. The identity pattern gives a zero residue. A codeword with one corrupted bit leaves a non-zero symptom.

In locate mode (`mode` = 0) the symptom is dialled onto the switches. The register is then clocked with a single one followed by zeros. It stops on the first shift whose result equals the switches, and the shift count at that point names the corrupted bit. The count is taken from the end of the codeword, so the last check bit is position 1. If no shift matches, the block halts at the end of the codeword and raises a no-match flag.

A synchronous reset restarts a run. The controller has only a run state and a halt state. The counter and the register advance only in the run state.

Top module: `ecl_locator`

## Requirements
- R1: The codeword is 15 bits long and is shifted in one fixed order. Data bits come from the store at addresses 0 to 10, in that order, with `rd_addr` equal to the number of shifts already done. Check bits follow from `sw[3]` down to `sw[0]`.
- R2: Each shift computes `next = {q[2:0], in} ^ (q[3] ? 4'b0011 : 4'b0000)`. This is division by x^4+x+1 with the input entering stage 0. `lfsr_q` shows the register outputs. In generate mode with `sw` = 0, the final value is the identity pattern.
- R3: In generate mode, with `sw` set to the identity pattern of the stored data, the final `lfsr_q` is 0. Corrupting any single codeword bit gives a non-zero final value, called the symptom.
- R4: In generate mode the block halts after exactly 15 shifts, with `pos` = 15 and `no_match` = 0.
- R5: In locate mode the input is 1 on the first shift and 0 on every later shift. The block halts on the first shift k whose resulting register value equals `sw`, leaving `pos` = k and `lfsr_q` = `sw`.
- R6: If the symptom comes from an error at stream index j (0 is the first data bit, 14 the last check bit), locate mode reports `pos` = 15 − j.
- R7: In locate mode with `sw` = 0 no shift matches. The block halts after 15 shifts with `no_match` = 1. `no_match` is 0 after every run that ends on a match or in generate mode.
- R8: When `rst` is high at a clock edge, `pos`, `lfsr_q`, `halted` and `no_match` are cleared and the run state is entered.
- R9: Once halted, `halted`, `pos` and `lfsr_q` hold until the next reset, whatever `rd_bit` does.
- R10: In the run state exactly one shift occurs per clock, and `pos` rises by one on each of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new run |
| mode | input | 1 | 1 = generate check pattern or symptom, 0 = locate error |
| sw | input | 4 | Check bits (generate) or symptom to find (locate) |
| rd_addr | output | 4 | Bit-store address of the bit being shifted |
| rd_bit | input | 1 | Data bit at `rd_addr` (combinational read) |
| lfsr_q | output | 4 | Shift register state |
| pos | output | 4 | Shift count; the error position after a locate run |
| halted | output | 1 | Controller is in the halt state |
| no_match | output | 1 | Locate run ended without a match |

## Verification
The bench injects an error at every one of the 15 codeword positions, including the four check bits. It then confirms that the symptom locates back to exactly that position. A design that feeds the check bits in the wrong order, or that counts one shift too many or too few, reports positions off by one or mirrored. Directed runs cover a symptom of 1, which must stop after a single shift, and a symptom of 0, which must run the full length and flag no match. A design that compares the register before it shifts, or that stops on terminal count without flagging, would report these wrongly. Halted outputs are watched while the stored data changes underneath, which catches a register that is not gated by the controller.

// File: rtl/ecl_pkg.sv
package ecl_pkg;

   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_HALT = 1'b1
   } run_state_e;

   function automatic int code_len(input int width);
      return (1 << width) - 1;
   endfunction

endpackage

// File: rtl/ecl_lfsr.sv
module ecl_lfsr #(
   parameter int             N    = 4,
   parameter logic [N-1:0]   POLY = 'b0011
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         din,
   output logic [N-1:0] q,
   output logic [N-1:0] q_next
);

   logic fb;
   assign fb = q[N-1];

   for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
         assign q_next[i] = din ^ (fb & POLY[i]);
      end else begin : g_rest
         assign q_next[i] = q[i-1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (en) q <= q_next;
   end

endmodule

// File: rtl/ecl_counter.sv
module ecl_counter #(
   parameter int CW   = 4,
   parameter int LAST = 14
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [CW-1:0] cnt,
   output logic          last
);

   assign last = (cnt == CW'(LAST));

   always_ff @(posedge clk) begin
      if (rst)     cnt <= '0;
      else if (en) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/ecl_ctrl.sv
module ecl_ctrl
   import ecl_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic mode,
   input  logic last,
   input  logic match,
   output logic run,
   output logic halted,
   output logic no_match
);

   run_state_e st;
   logic       stop;

   assign run    = (st == ST_RUN);
   assign halted = (st == ST_HALT);
   assign stop   = mode ? last : (match | last);

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_RUN;
         no_match <= 1'b0;
      end else if (run && stop) begin
         st       <= ST_HALT;
         no_match <= ~mode & last & ~match;
      end
   end

endmodule

// File: rtl/ecl_locator.sv
module ecl_locator
   import ecl_pkg::*;
#(
   parameter int           N    = 4,
   parameter logic [N-1:0] POLY = 'b0011,
   localparam int          MSG_LEN = (1 << N) - 1,
   localparam int          CW      = $clog2(MSG_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          mode,
   input  logic [N-1:0]  sw,
   output logic [CW-1:0] rd_addr,
   input  logic          rd_bit,
   output logic [N-1:0]  lfsr_q,
   output logic [CW-1:0] pos,
   output logic          halted,
   output logic          no_match
);

   localparam int DATA_LEN = MSG_LEN - N;

   if (N < 2) begin : g_bad_n
      $error("ecl_locator: N must be at least 2");
   end
   if (!POLY[0]) begin : g_bad_poly
      $error("ecl_locator: POLY must include the constant term");
   end
   if (code_len(N) != MSG_LEN) begin : g_bad_len
      $error("ecl_locator: length mismatch");
   end

   logic          run;
   logic          last;
   logic          match;
   logic          in_bit;
   logic [N-1:0]  lfsr_nxt;
   logic [CW-1:0] par_off;
   logic [N-1:0]  sw_shifted;
   logic          gen_bit;
   logic          loc_bit;

   assign rd_addr    = pos;
   assign par_off    = pos - CW'(DATA_LEN);
   assign sw_shifted = sw << par_off;
   assign gen_bit    = (pos < CW'(DATA_LEN)) ? rd_bit : sw_shifted[N-1];
   assign loc_bit    = (pos == '0);
   assign in_bit     = mode ? gen_bit : loc_bit;
   assign match      = (lfsr_nxt == sw);

   ecl_counter #(
      .CW   (CW),
      .LAST (MSG_LEN - 1)
   ) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .en   (run),
      .cnt  (pos),
      .last (last)
   );

   ecl_lfsr #(
      .N    (N),
      .POLY (POLY)
   ) u_lfsr (
      .clk    (clk),
      .rst    (rst),
      .en     (run),
      .din    (in_bit),
      .q      (lfsr_q),
      .q_next (lfsr_nxt)
   );

   ecl_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode),
      .last     (last),
      .match    (match),
      .run      (run),
      .halted   (halted),
      .no_match (no_match)
   );

endmodule

// File: rtl/ecl_locator_chk.sv
module ecl_locator_chk #(
   parameter int N = 4,
   localparam int MSG_LEN = (1 << N) - 1,
   localparam int CW      = $clog2(MSG_LEN + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic          mode,
   input logic [N-1:0]  sw,
   input logic [N-1:0]  lfsr_q,
   input logic [CW-1:0] pos,
   input logic          halted,
   input logic          no_match
);

   // R10
   pos_step_chk: assert property (@(posedge clk) disable iff (rst)
      !halted |=> (pos == $past(pos) + 1'b1));

   // R9
   halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(pos) && $stable(lfsr_q)));

   // R4
   gen_len_chk: assert property (@(posedge clk) disable iff (rst)
      (halted && mode) |-> (pos == CW'(MSG_LEN) && !no_match));

   // R7
   nomatch_len_chk: assert property (@(posedge clk) disable iff (rst)
      no_match |-> (halted && pos == CW'(MSG_LEN)));

   // R5
   loc_match_chk: assert property (@(posedge clk) disable iff (rst)
      (halted && !mode && !no_match) |-> (lfsr_q == sw));

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (pos == '0 && lfsr_q == '0 && !halted && !no_match));

endmodule

bind ecl_locator ecl_locator_chk #(.N(N)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mode     (mode),
   .sw       (sw),
   .lfsr_q   (lfsr_q),
   .pos      (pos),
   .halted   (halted),
   .no_match (no_match)
);

// File: tb/ecl_locator_tb.sv
module ecl_locator_tb;

   localparam int N    = 4;
   localparam int LEN  = 15;
   localparam int DLEN = 11;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mode = 1'b1;
   logic [3:0]  sw = '0;
   logic [3:0]  rd_addr;
   logic        rd_bit;
   logic [3:0]  lfsr_q;
   logic [3:0]  pos;
   logic        halted;
   logic        no_match;
   logic [10:0] rom = '0;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   always_comb begin
      if (rd_addr < 4'(DLEN)) rd_bit = rom[DLEN - 1 - int'(rd_addr)];
      else                    rd_bit = 1'b0;
   end

   ecl_locator u_dut (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode),
      .sw       (sw),
      .rd_addr  (rd_addr),
      .rd_bit   (rd_bit),
      .lfsr_q   (lfsr_q),
      .pos      (pos),
      .halted   (halted),
      .no_match (no_match)
   );

   function automatic logic [3:0] step(input logic [3:0] s, input logic b);
      return {s[2:0], b} ^ (s[3] ? 4'b0011 : 4'b0000);
   endfunction

   function automatic logic [3:0] residue(input logic [10:0] d, input logic [3:0] p);
      logic [3:0] s = '0;
      for (int i = 0; i < LEN; i++) begin
         s = step(s, (i < DLEN) ? d[DLEN - 1 - i] : p[3 - (i - DLEN)]);
      end
      return s;
   endfunction

   function automatic int impulse_pos(input logic [3:0] target);
      logic [3:0] s = '0;
      for (int k = 1; k <= LEN; k++) begin
         s = step(s, k == 1);
         if (s == target) return k;
      end
      return LEN;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_run(input logic m, input logic [3:0] s, output int cyc);
      @(negedge clk);
      rst  = 1'b1;
      mode = m;
      sw   = s;
      @(negedge clk);
      check(pos == 0 && lfsr_q == 0 && !halted && !no_match, "R8 reset clears",
            int'({pos, lfsr_q, halted, no_match}), 0);
      rst = 1'b0;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!halted && cyc < 40);
   endtask

   task automatic gen_run(input logic [10:0] d, input logic [3:0] p,
                          input string req, input logic [3:0] exp_q);
      int cyc;
      rom = d;
      do_run(1'b1, p, cyc);
      check(lfsr_q == exp_q, req, lfsr_q, exp_q);
      check(cyc == LEN && pos == 4'(LEN) && !no_match, "R4 generate length", cyc, LEN);
   endtask

   task automatic locate(input logic [10:0] d, input int j);
      logic [10:0] dc;
      logic [3:0]  id;
      logic [3:0]  pc;
      logic [3:0]  sym;
      int          cyc;
      id = residue(d, 4'h0);
      dc = d;
      pc = id;
      if (j < DLEN) dc[DLEN - 1 - j] = ~dc[DLEN - 1 - j];
      else          pc[3 - (j - DLEN)] = ~pc[3 - (j - DLEN)];
      sym = residue(dc, pc);
      gen_run(dc, pc, "R1 R2 symptom from corrupted stream", sym);
      check(lfsr_q != 0, "R3 symptom non-zero", lfsr_q, 1);
      do_run(1'b0, sym, cyc);
      check(pos == 4'(LEN - j) && !no_match, "R6 error position", pos, LEN - j);
      check(cyc == LEN - j && lfsr_q == sym, "R5 stops on match", cyc, LEN - j);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int          cyc;
      logic [10:0] d;
      logic [3:0]  id;
      void'($urandom(32'h5EED));

      // directed: all-zero data, identity is zero
      gen_run(11'h000, 4'h0, "R2 zero data identity", 4'h0);

      // directed: a single data one, identity equals x^14 mod g
      gen_run(11'h400, 4'h0, "R2 identity of MSB only", residue(11'h400, 4'h0));

      // directed: check bits alone reach the register MSB first
      gen_run(11'h000, 4'b1000, "R1 check bit order", 4'b1000);
      gen_run(11'h000, 4'b0001, "R1 check bit order", 4'b0001);

      // locate with symptom 1: one shift
      do_run(1'b0, 4'h1, cyc);
      check(cyc == 1 && pos == 1 && !no_match, "R5 symptom one", pos, 1);

      // locate with symptom 0: no match
      do_run(1'b0, 4'h0, cyc);
      check(cyc == LEN && pos == 4'(LEN) && no_match, "R7 no match", int'(no_match), 1);

      // a few symptoms checked against the impulse model
      do_run(1'b0, 4'b1001, cyc);
      check(pos == 4'(impulse_pos(4'b1001)) && !no_match, "R5 symptom 1001",
            pos, impulse_pos(4'b1001));
      do_run(1'b0, 4'b1000, cyc);
      check(pos == 4'(impulse_pos(4'b1000)), "R10 count per shift", pos, impulse_pos(4'b1000));

      // halt freezes outputs while the store changes
      rom = 11'h2B5;
      do_run(1'b1, 4'h0, cyc);
      id = lfsr_q;
      for (int t = 0; t < 6; t++) begin
         @(negedge clk);
         rom = 11'($urandom);
      end
      check(halted && pos == 4'(LEN) && lfsr_q == id, "R9 halt holds", lfsr_q, id);

      // every position for one fixed word
      for (int j = 0; j < LEN; j++) locate(11'h5A3, j);

      // random words
      for (int r = 0; r < 12; r++) begin
         d  = 11'($urandom);
         id = residue(d, 4'h0);
         gen_run(d, 4'h0, "R2 identity pattern", id);
         gen_run(d, id, "R3 zero residue", 4'h0);
         locate(d, int'($urandom % LEN));
      end

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule